// File: doc/BRIEF.md
# Timer Channel Status Flags

This block keeps the event flags of one 16-bit timer channel. It contains the channel's up/down counter and two general registers, A and B. Each general register acts either as a compare register, which flags the cycle where the running counter equals it, or as a capture register, which latches the counter on a rising edge of its capture pin. A third flag records a counter wrap, up or down.

Software reads the flags through a byte-wide status port and clears them. A flag can be cleared only by reading it as 1 and then writing 0 to its bit. A write of 1 never sets a flag. Hardware events always take priority over a clearing write in the same cycle. The counter and both general registers can be preloaded through a shared load port, so a test can reach the wrap boundaries quickly.

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset, all three flags are 0, the status byte reads 0xF8, the counter is 0x0000 and both general registers are 0xFFFF.
- R2: Status bits 7..3 always read as 1, and writes to them change nothing.
- R3: A counter load takes priority over counting. With the counter enabled, it steps by +1 when the direction input is 0 and by -1 when it is 1. Each change is visible after one clock edge.
- R4: Counting up from 0xFFFF wraps the counter to 0x0000 and sets status bit 2 on that same edge.
- R5: Counting down from 0x0000 wraps the counter to 0xFFFF and sets status bit 2 on that same edge.
- R6: In compare mode (mode bit = 0), a cycle where the counter is enabled and equals general register A (or B) sets status bit 0 (or bit 1) at the next edge.
- R7: In capture mode (mode bit = 1), a rising edge on the capture pin passes through a 2-stage synchroniser. The third clock edge after the pin rises copies the counter into the register and sets its flag. A capture beats a load of the same register.
- R8: Writing 1 to a flag bit never sets that flag.
- R9: Writing 0 to a set flag that has not been read as 1 since it was last disarmed leaves the flag set.
- R10: A read that returns 1 for a flag arms that flag. A later write of 0 to its bit clears it. A write of 1 to its bit disarms it and leaves the flag set.
- R11: If a hardware set and a clearing write hit the same flag in one cycle, the flag stays set and is disarmed. A further write of 0 then leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter enable |
| cnt_dn_i | input | 1 | Count direction, 1 = down |
| cnt_ld_i | input | 1 | Load counter from ld_data_i |
| gr_ld_i | input | 2 | Load general register B (bit 1) or A (bit 0) from ld_data_i |
| ld_data_i | input | 16 | Shared load value |
| gr_mode_i | input | 2 | Per-register mode, 0 = compare, 1 = capture |
| cap_i | input | 2 | Asynchronous capture pins for B (bit 1) and A (bit 0) |
| bus_rd_i | input | 1 | Status read strobe |
| bus_wr_i | input | 1 | Status write strobe |
| bus_wdata_i | input | 8 | Status write data |
| bus_rdata_o | output | 8 | Status byte: bit 2 wrap, bit 1 B, bit 0 A, bits 7..3 = 1 |
| cnt_o | output | 16 | Counter value |
| gr_a_o | output | 16 | General register A |
| gr_b_o | output | 16 | General register B |

## Verification
The bench first targets the clear protocol. It writes 0 to a set flag with no prior read; a design that ignores arming would drop the flag. It writes 1 after a read; a design that skips disarming would let a later bare 0 clear the flag. It lands a compare match on the same cycle as a clearing write; a design with the wrong priority would lose the event. Wraps in both directions are driven from preloaded boundary values, where an off-by-one wrap test would miss or double-set the overflow flag. The capture path is checked on the exact latency edge, and a long randomized run compares every output against a cycle model in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    GR_CMP = 1'b0,
    GR_CAP = 1'b1
  } gr_mode_e;

  localparam int unsigned NUM_GR  = 2;
  localparam int unsigned NUM_FLG = NUM_GR + 1;
  localparam int unsigned FLG_WRAP = NUM_GR;
endpackage

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         dn_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (ld_i) cnt_q <= ld_data_i;
    else if (en_i) cnt_q <= dn_i ? cnt_q - ONE : cnt_q + ONE;
  end

  assign wrap_o = en_i & ~ld_i & (dn_i ? (cnt_q == '0) : (cnt_q == ALL1));
  assign cnt_o  = cnt_q;

  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_i && !dn_i) |=> cnt_q == $past(cnt_q) + ONE);
  assert_up_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_i && !dn_i && cnt_q == ALL1) |=> cnt_q == '0);
  assert_down_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_i && dn_i && cnt_q == '0) |=> cnt_q == ALL1);
endmodule

// File: rtl/tmr_gr.sv
module tmr_gr
  import tmr_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned SYNC  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  gr_mode_e     mode_i,
  input  logic         cap_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  input  logic [W-1:0] cnt_i,
  input  logic         cnt_en_i,
  output logic [W-1:0] gr_o,
  output logic         evt_o
);
  logic [SYNC:0] sync_q;
  logic [W-1:0]  gr_q;
  logic          rise, cap_evt, cmp_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC-1:0], cap_i};
  end

  assign rise    = sync_q[SYNC-1] & ~sync_q[SYNC];
  assign cap_evt = (mode_i == GR_CAP) & rise;
  assign cmp_evt = (mode_i == GR_CMP) & cnt_en_i & (cnt_i == gr_q);

  // capture beats software load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gr_q <= '1;
    else if (cap_evt) gr_q <= cnt_i;
    else if (ld_i)    gr_q <= ld_data_i;
  end

  assign gr_o  = gr_q;
  assign evt_o = cap_evt | cmp_evt;

  assert_capture_copy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> gr_q == $past(cnt_i));
  assert_cmp_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == GR_CMP && !ld_i) |=> $stable(gr_q));
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, armed_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr;
    assign clr = wr_i & ~wdata_i[i] & armed_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[i]  <= 1'b0;
        armed_q[i] <= 1'b0;
      end else begin
        flag_q[i] <= set_i[i] | (flag_q[i] & ~clr);
        if (wr_i)                   armed_q[i] <= 1'b0;
        else if (rd_i && flag_q[i]) armed_q[i] <= 1'b1;
      end
    end

    assert_sw_never_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_q[i] && !set_i[i]) |=> !flag_q[i]);
    assert_clear_needs_arm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !armed_q[i]) |=> flag_q[i]);
    assert_armed_implies_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q[i] |-> flag_q[i]);
    assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned BUS_W = 8,
  parameter int unsigned SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             cnt_dn_i,
  input  logic             cnt_ld_i,
  input  logic [1:0]       gr_ld_i,
  input  logic [CNT_W-1:0] ld_data_i,
  input  logic [1:0]       gr_mode_i,
  input  logic [1:0]       cap_i,
  input  logic             bus_rd_i,
  input  logic             bus_wr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] gr_a_o,
  output logic [CNT_W-1:0] gr_b_o
);
  localparam int unsigned RSV_W = BUS_W - NUM_FLG;

  logic [CNT_W-1:0]   cnt;
  logic               wrap;
  logic [CNT_W-1:0]   gr_val [NUM_GR];
  logic [NUM_FLG-1:0] set, flags;
  logic               unused_rsv;

  tmr_cnt #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i      (cnt_en_i),
    .dn_i      (cnt_dn_i),
    .ld_i      (cnt_ld_i),
    .ld_data_i (ld_data_i),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
    tmr_gr #(.W(CNT_W), .SYNC(SYNC)) u_gr (
      .clk_i, .rst_ni,
      .mode_i    (gr_mode_e'(gr_mode_i[g])),
      .cap_i     (cap_i[g]),
      .ld_i      (gr_ld_i[g]),
      .ld_data_i (ld_data_i),
      .cnt_i     (cnt),
      .cnt_en_i  (cnt_en_i),
      .gr_o      (gr_val[g]),
      .evt_o     (set[g])
    );
  end

  assign set[FLG_WRAP] = wrap;

  tmr_flag_reg #(.N(NUM_FLG)) u_flags (
    .clk_i, .rst_ni,
    .set_i   (set),
    .rd_i    (bus_rd_i),
    .wr_i    (bus_wr_i),
    .wdata_i (bus_wdata_i[NUM_FLG-1:0]),
    .flag_o  (flags)
  );

  assign unused_rsv  = ^bus_wdata_i[BUS_W-1:NUM_FLG];
  assign bus_rdata_o = {{RSV_W{1'b1}}, flags};
  assign cnt_o       = cnt;
  assign gr_a_o      = gr_val[0];
  assign gr_b_o      = gr_val[1];

  assert_wrap_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !cnt_ld_i && !cnt_dn_i && cnt == '1) |=> bus_rdata_o[FLG_WRAP]);
  assert_underflow_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !cnt_ld_i && cnt_dn_i && cnt == '0) |=> bus_rdata_o[FLG_WRAP]);
endmodule

// File: tb/tmr_flag_unit_tb.sv
module tmr_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 0, cnt_dn = 0, cnt_ld = 0;
  logic [1:0]  gr_ld = 0, gr_mode = 0, cap = 0;
  logic [15:0] ld_data = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic [15:0] cnt, gr_a, gr_b;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [15:0] m_cnt = 16'h0000;
  logic [15:0] m_gr [2] = '{16'hFFFF, 16'hFFFF};
  logic [2:0]  m_flg = 3'b000, m_arm = 3'b000;
  logic [1:0]  m_s1 = 0, m_s2 = 0, m_s3 = 0;

  always #5 clk = ~clk;

  tmr_flag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cnt_en_i(cnt_en), .cnt_dn_i(cnt_dn), .cnt_ld_i(cnt_ld),
    .gr_ld_i(gr_ld), .ld_data_i(ld_data), .gr_mode_i(gr_mode), .cap_i(cap),
    .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .cnt_o(cnt), .gr_a_o(gr_a), .gr_b_o(gr_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic flag_next(logic f, logic a, logic s, logic wr, logic wd);
    return s | (f & ~(wr & ~wd & a));
  endfunction

  function automatic logic arm_next(logic f, logic a, logic rd, logic wr);
    if (wr) return 1'b0;
    if (rd && f) return 1'b1;
    return a;
  endfunction

  function automatic logic [15:0] cnt_next(logic [15:0] c, logic en, logic dn, logic ld, logic [15:0] d);
    if (ld) return d;
    if (en) return dn ? c - 16'd1 : c + 16'd1;
    return c;
  endfunction

  task automatic model_step();
    logic [2:0] set;
    logic [1:0] rise;
    logic [15:0] gr_n [2];
    rise = m_s2 & ~m_s3;
    set[2] = cnt_en & ~cnt_ld & (cnt_dn ? (m_cnt == 16'h0000) : (m_cnt == 16'hFFFF));
    for (int i = 0; i < 2; i++) begin
      logic ce, me;
      ce = gr_mode[i] & rise[i];
      me = ~gr_mode[i] & cnt_en & (m_cnt == m_gr[i]);
      set[i] = ce | me;
      gr_n[i] = ce ? m_cnt : (gr_ld[i] ? ld_data : m_gr[i]);
    end
    for (int i = 0; i < 3; i++) begin
      logic f;
      f = m_flg[i];
      m_flg[i] = flag_next(f, m_arm[i], set[i], bus_wr, bus_wdata[i]);
      m_arm[i] = arm_next(f, m_arm[i], bus_rd, bus_wr);
    end
    m_gr[0] = gr_n[0];
    m_gr[1] = gr_n[1];
    m_cnt = cnt_next(m_cnt, cnt_en, cnt_dn, cnt_ld, ld_data);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap;
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " status"}, {24'h0, bus_rdata}, {24'h0, 5'h1F, m_flg});
    chk({tag, " cnt"}, {16'h0, cnt}, {16'h0, m_cnt});
    chk({tag, " gr_a"}, {16'h0, gr_a}, {16'h0, m_gr[0]});
    chk({tag, " gr_b"}, {16'h0, gr_b}, {16'h0, m_gr[1]});
    bus_rd = 0; bus_wr = 0; cnt_ld = 0; gr_ld = 0;
  endtask

  task automatic rd_st(input string tag); bus_rd = 1; tick(tag); endtask
  task automatic wr_st(input string tag, input logic [7:0] d); bus_wr = 1; bus_wdata = d; tick(tag); endtask
  task automatic ld_cnt(input string tag, input logic [15:0] d); cnt_ld = 1; ld_data = d; tick(tag); endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1 reset status", {24'h0, bus_rdata}, 32'hF8);
    chk("R1 reset cnt", {16'h0, cnt}, 32'h0);
    chk("R1 reset gr_a", {16'h0, gr_a}, 32'hFFFF);
    rst_n = 1;
    @(negedge clk);

    wr_st("R2 R8 write ones", 8'hFF);
    chk("R2 R8 no flag from write", {24'h0, bus_rdata}, 32'hF8);

    // up wrap
    gr_ld = 2'b11; ld_data = 16'h4000; tick("R3 gr preload");
    ld_cnt("R3 load", 16'hFFFE);
    cnt_en = 1; cnt_dn = 0;
    tick("R3 up");
    chk("R3 up step", {16'h0, cnt}, 32'hFFFF);
    tick("R4 wrap");
    cnt_en = 0;
    chk("R4 up wrap flag", {31'h0, bus_rdata[2]}, 32'h1);
    chk("R4 up wrap cnt", {16'h0, cnt}, 32'h0);
    wr_st("R9 clear no read", 8'h00);
    chk("R9 clear without read ignored", {31'h0, bus_rdata[2]}, 32'h1);
    rd_st("R10 read");
    wr_st("R10 clear", 8'h00);
    chk("R10 clear after read", {31'h0, bus_rdata[2]}, 32'h0);

    // down wrap
    ld_cnt("R3 load", 16'h0001);
    cnt_en = 1; cnt_dn = 1;
    tick("R3 down");
    chk("R3 down step", {16'h0, cnt}, 32'h0);
    tick("R5 wrap");
    cnt_en = 0; cnt_dn = 0;
    chk("R5 down wrap flag", {31'h0, bus_rdata[2]}, 32'h1);
    chk("R5 down wrap cnt", {16'h0, cnt}, 32'hFFFF);
    rd_st("R10 read");
    wr_st("R10 write one", 8'h04);
    chk("R10 write one keeps flag", {31'h0, bus_rdata[2]}, 32'h1);
    wr_st("R10 disarmed", 8'h00);
    chk("R10 write one disarms", {31'h0, bus_rdata[2]}, 32'h1);
    rd_st("R10 read");
    wr_st("R10 clear", 8'h00);
    chk("R10 clear after rearm", {31'h0, bus_rdata[2]}, 32'h0);

    // compare A and B
    gr_mode = 2'b00;
    gr_ld = 2'b01; ld_data = 16'h0010; tick("R6 load A");
    gr_ld = 2'b10; ld_data = 16'h0012; tick("R6 load B");
    ld_cnt("R6 load cnt", 16'h000E);
    cnt_en = 1;
    tick("R6"); tick("R6");
    chk("R6 A not yet", {31'h0, bus_rdata[0]}, 32'h0);
    tick("R6");
    chk("R6 compare A", {31'h0, bus_rdata[0]}, 32'h1);
    tick("R6");
    chk("R6 B not yet", {31'h0, bus_rdata[1]}, 32'h0);
    tick("R6");
    cnt_en = 0;
    chk("R6 compare B", {31'h0, bus_rdata[1]}, 32'h1);

    // set vs clear same cycle on A
    rd_st("R11 read");
    ld_cnt("R11 load", 16'h0010);
    cnt_en = 1; bus_wr = 1; bus_wdata = 8'h00;
    tick("R11 collide");
    cnt_en = 0;
    chk("R11 set wins", {31'h0, bus_rdata[0]}, 32'h1);
    chk("R11 B cleared same write", {31'h0, bus_rdata[1]}, 32'h0);
    wr_st("R11 bare clear", 8'h00);
    chk("R11 disarmed after collision", {31'h0, bus_rdata[0]}, 32'h1);
    rd_st("R11 read");
    wr_st("R11 clear", 8'h00);

    // capture on A
    gr_mode = 2'b01;
    ld_cnt("R7 load", 16'h1234);
    cap = 2'b01;
    tick("R7 sync1");
    tick("R7 sync2");
    chk("R7 not yet", {16'h0, gr_a}, 32'h0010);
    tick("R7 capture");
    chk("R7 captured value", {16'h0, gr_a}, 32'h1234);
    chk("R7 capture flag", {31'h0, bus_rdata[0]}, 32'h1);
    cap = 2'b00;
    tick("R7 idle");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 16 == 0) cnt_dn = $urandom_range(0, 1);
      if (n % 64 == 0) gr_mode = 2'($urandom);
      cnt_en = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 7) == 0) cap = cap ^ 2'($urandom);
      if ($urandom_range(0, 31) == 0) begin
        cnt_ld = 1;
        case ($urandom_range(0, 2))
          0: ld_data = 16'hFFFD + 16'($urandom_range(0, 2));
          1: ld_data = 16'($urandom_range(0, 2));
          default: ld_data = 16'($urandom);
        endcase
      end else if ($urandom_range(0, 31) == 0) begin
        gr_ld = 2'($urandom_range(1, 3));
        ld_data = m_cnt + 16'($urandom_range(0, 6)) - 16'd3;
      end
      bus_rd = ($urandom_range(0, 3) == 0);
      bus_wr = ($urandom_range(0, 3) == 0);
      bus_wdata = 8'($urandom);
      tick("R3 R6 R7 R8 R10 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule